// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a configuration bitstream into an FPGA through its slave-serial port. A start pulse sets up a run. The block then drops the active-low program line for one phase period, waits a fixed number of cycles while the target device clears its configuration memory, and checks that the synchronized status input reads low. If it does, the block takes bytes from a valid/ready stream and shifts each one out on the data line, most significant bit first. Each bit gets one clock pulse.

After the last bit, the block waits long enough for the status line to pass through its synchronizer. It then reads the line once more: high means the device has accepted the stream. The outcome is reported as a two-bit result code with a done flag. Both outputs hold until the next start.

The phase period and the byte count are inputs and are captured at start. The memory-clear wait is a cycle-count parameter. The default corresponds to 50 ms at a 100 MHz clock.

Top module: `fpgacfg_master`

## Requirements
- R1: When start is accepted in idle, `cfg_prog_n` goes low one cycle later and stays low for exactly P cycles, where P is the captured phase length. `cfg_cs` (active high) stays high from then until the result is posted.
- R2: After `cfg_prog_n` returns high, the block waits exactly CLEAR_CYCLES cycles before it first raises `in_ready`.
- R3: If the synchronized status reads high at the end of the clear wait, the run ends with `err_code` = 1. No CCLK pulse is produced and `in_ready` is never raised.
- R4: Each byte is shifted out most significant bit first, with exactly 8 CCLK pulses per byte. `cfg_din` already holds the bit when CCLK rises.
- R5: Every bit has three phases: a setup phase of P cycles with CCLK low, then CCLK high for 2·P cycles, then CCLK low for P cycles. `cfg_din` does not change while CCLK is high.
- R6: After the last bit, a high status gives `err_code` = 0 with `ok` = 1. A low status gives `err_code` = 2 with `ok` = 0.
- R7: A phase input of 0 is treated as a phase length of 1.
- R8: `in_ready` is high only between bytes. A new byte is taken only after the previous byte's 8 bits are done, and CCLK stays low while the stream stalls.
- R9: The status input passes through a two-flop synchronizer. The result is posted exactly P + 4 cycles after the last CCLK falling edge.
- R10: A start pulse while `busy` is high is ignored: no new program pulse and no restart.
- R11: `done` and `err_code` hold after a run until the next accepted start. That start clears `done` and raises `busy`.
- R12: A byte count of 0 skips the shift entirely: no CCLK pulse, no `in_ready`, and only the final status check.
- R13: After reset, `busy`, `done`, `cfg_cclk`, `cfg_cs` and `in_ready` are low, and `cfg_prog_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| byte_total | input | CNT_W | Number of bytes to send, captured at start |
| phase_cycles | input | PH_W | Phase length in clock cycles, captured at start (0 means 1) |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block takes a byte this cycle if valid |
| cfg_prog_n | output | 1 | Program line to the FPGA, active low |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_din | output | 1 | Configuration serial data |
| cfg_cs | output | 1 | Chip-select enable of the configuration pins, active high |
| cfg_status | input | 1 | Busy/done status from the FPGA, asynchronous |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| ok | output | 1 | Run finished with result 0 |
| err_code | output | 2 | 0 success, 1 no clear acknowledge, 2 configuration not done |

## Verification
All timing is counted from registered state. The program pulse starts one cycle after the start edge and lasts P cycles. The first `in_ready` comes CLEAR_CYCLES cycles after the program line is released. Each CCLK high lasts 2·P cycles, and `done` rises P + 4 cycles after the last falling edge of CCLK. The bench samples every output on the falling clock edge and counts samples between these events, so each count must equal the expected value exactly. A monitor pops the expected bit from the scoreboard queue on each CCLK rising edge, and the result code is compared only after `done` is seen.

// File: rtl/fpgacfg_pkg.sv
package fpgacfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_CLEAR,
        ST_FETCH,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_DRAIN
    } cfg_state_e;

    typedef enum logic [1:0] {
        RES_OK           = 2'd0,
        RES_NO_CLEAR_ACK = 2'd1,
        RES_NOT_DONE     = 2'd2
    } cfg_result_e;

endpackage

// File: rtl/fpgacfg_sync.sv
// Multi-stage synchronizer for the asynchronous status pin.
module fpgacfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stg_d = async_in;
        end else begin : g_chain
            always_comb stg_d = {stg_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/fpgacfg_timer.sv
// Down-counter: loaded with N-1, expired in the N-th cycle after the load.
module fpgacfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fpgacfg_shifter.sv
// Holds one byte and presents it MSB first, one bit per shift.
module fpgacfg_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    output logic       bit_out,
    output logic       last_bit
);
    typedef struct packed {
        logic [7:0] data;
        logic [2:0] idx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.data = load_byte;
            sh_d.idx  = 3'd0;
        end else if (shift) begin
            sh_d.data = {sh_q.data[6:0], 1'b0};
            sh_d.idx  = sh_q.idx + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_out  = sh_q.data[7];
    assign last_bit = (sh_q.idx == 3'd7);
endmodule

// File: rtl/fpgacfg_master.sv
module fpgacfg_master
    import fpgacfg_pkg::*;
#(
    parameter int CLEAR_CYCLES = 5_000_000,
    parameter int PH_W         = 8,
    parameter int CNT_W        = 24,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_total,
    input  logic [PH_W-1:0]  phase_cycles,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             cfg_prog_n,
    output logic             cfg_cclk,
    output logic             cfg_din,
    output logic             cfg_cs,
    input  logic             cfg_status,
    output logic             busy,
    output logic             done,
    output logic             ok,
    output logic [1:0]       err_code
);
    localparam int CLR_W        = $clog2(CLEAR_CYCLES + 1);
    localparam int TMR_W        = (CLR_W > PH_W + 1) ? CLR_W : PH_W + 1;
    localparam int DRAIN_CYCLES = SYNC_STAGES + 2;

    localparam logic [TMR_W-1:0] T_ONE      = TMR_W'(1);
    localparam logic [TMR_W-1:0] CLEAR_M1   = TMR_W'(CLEAR_CYCLES - 1);
    localparam logic [TMR_W-1:0] DRAIN_M1   = TMR_W'(DRAIN_CYCLES - 1);

    typedef struct packed {
        cfg_state_e  state;
        logic [CNT_W-1:0] bytes_left;
        logic [PH_W-1:0]  ph;
        logic        done;
        cfg_result_e err;
        logic        cs;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             status_s;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_bit;
    logic             sh_last;
    logic [PH_W-1:0]  ph_in;
    logic [TMR_W-1:0] ph_m1;
    logic [TMR_W-1:0] hi_m1;

    fpgacfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cfg_status),
        .sync_out (status_s)
    );

    fpgacfg_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    fpgacfg_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (in_data),
        .shift     (sh_shift),
        .bit_out   (sh_bit),
        .last_bit  (sh_last)
    );

    assign ph_in = (phase_cycles == '0) ? PH_W'(1) : phase_cycles;
    assign ph_m1 = TMR_W'(r_q.ph) - T_ONE;
    assign hi_m1 = (TMR_W'(r_q.ph) << 1) - T_ONE;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state      = ST_PROG;
                    r_d.bytes_left = byte_total;
                    r_d.ph         = ph_in;
                    r_d.done       = 1'b0;
                    r_d.err        = RES_OK;
                    r_d.cs         = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = TMR_W'(ph_in) - T_ONE;
                end
            end
            ST_PROG: begin
                if (tmr_done) begin
                    r_d.state = ST_CLEAR;
                    tmr_load  = 1'b1;
                    tmr_val   = CLEAR_M1;
                end
            end
            ST_CLEAR: begin
                if (tmr_done) begin
                    if (status_s) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.cs    = 1'b0;
                        r_d.err   = RES_NO_CLEAR_ACK;
                    end else if (r_q.bytes_left == '0) begin
                        r_d.state = ST_DRAIN;
                        tmr_load  = 1'b1;
                        tmr_val   = DRAIN_M1;
                    end else begin
                        r_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (in_valid) begin
                    sh_load        = 1'b1;
                    r_d.bytes_left = r_q.bytes_left - 1'b1;
                    r_d.state      = ST_SETUP;
                    tmr_load       = 1'b1;
                    tmr_val        = ph_m1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    r_d.state = ST_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = hi_m1;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    r_d.state = ST_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = ph_m1;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    if (!sh_last) begin
                        sh_shift  = 1'b1;
                        r_d.state = ST_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = ph_m1;
                    end else if (r_q.bytes_left == '0) begin
                        r_d.state = ST_DRAIN;
                        tmr_load  = 1'b1;
                        tmr_val   = DRAIN_M1;
                    end else begin
                        r_d.state = ST_FETCH;
                    end
                end
            end
            ST_DRAIN: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.cs    = 1'b0;
                    r_d.err   = status_s ? RES_OK : RES_NOT_DONE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state      <= ST_IDLE;
            r_q.bytes_left <= '0;
            r_q.ph         <= PH_W'(1);
            r_q.done       <= 1'b0;
            r_q.err        <= RES_OK;
            r_q.cs         <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready   = (r_q.state == ST_FETCH);
    assign cfg_prog_n = (r_q.state != ST_PROG);
    assign cfg_cclk   = (r_q.state == ST_HIGH);
    assign cfg_din    = sh_bit;
    assign cfg_cs     = r_q.cs;
    assign busy       = (r_q.state != ST_IDLE);
    assign done       = r_q.done;
    assign ok         = r_q.done && (r_q.err == RES_OK);
    assign err_code   = r_q.err;
endmodule

// File: rtl/fpgacfg_master_chk.sv
module fpgacfg_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_ready,
    input logic       cfg_prog_n,
    input logic       cfg_cclk,
    input logic       cfg_din,
    input logic       cfg_cs,
    input logic       busy,
    input logic       done,
    input logic       ok,
    input logic [1:0] err_code
);
    // R1
    prog_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> (busy && cfg_cs));

    // R5
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));

    // R8
    stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!cfg_cclk && cfg_prog_n && busy));

    // R6
    ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (done && err_code == 2'd0 && !busy));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_code)));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_prog_n && start) |=> cfg_prog_n);
endmodule

bind fpgacfg_master fpgacfg_master_chk u_chk (.*);

// File: tb/tb_fpgacfg_master.sv
module tb_fpgacfg_master;
    localparam int CLK_PERIOD = 10;
    localparam int CLEAR      = 40;
    localparam int PH_W       = 4;
    localparam int CNT_W      = 8;
    localparam int MODE_OK    = 0;
    localparam int MODE_STUCK = 1;
    localparam int MODE_NEVER = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_total = '0;
    logic [PH_W-1:0]  phase_cycles = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             cfg_prog_n, cfg_cclk, cfg_din, cfg_cs;
    logic             cfg_status;
    logic             busy, done, ok;
    logic [1:0]       err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpgacfg_master #(
        .CLEAR_CYCLES(CLEAR), .PH_W(PH_W), .CNT_W(CNT_W), .SYNC_STAGES(2)
    ) dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // scoreboard and per-run observations
    bit exp_q[$];
    int mode = MODE_OK;
    int p_exp = 1;
    int exp_rises = 0;
    int rises, prog_lo, clr_cnt, clr_meas, hi_run, fall_gap;
    int clr_state;
    bit ready_seen, fall_seen, prev_cclk;

    task automatic chk(input bit cond, input string req, input longint act, input longint exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: device model plus scoreboard pop
    always @(negedge clk) begin
        if (!rst_n) begin
            cfg_status <= 1'b1;
            prev_cclk  <= 1'b0;
        end else begin
            if (in_ready) ready_seen = 1'b1;
            if (!cfg_prog_n) begin
                prog_lo++;
                cfg_status <= (mode == MODE_STUCK);
                clr_state = 1;
                clr_cnt   = 0;
            end else if (clr_state == 1) begin
                if (in_ready)   begin clr_meas = clr_cnt; clr_state = 2; end
                else if (!busy) clr_state = 2;
                else            clr_cnt++;
            end
            if (cfg_cclk && !prev_cclk) begin
                rises++;
                hi_run = 1;
                if (exp_q.size() == 0) chk(1'b0, "R4 extra clock", rises, exp_rises);
                else begin
                    automatic bit e = exp_q.pop_front();
                    chk(cfg_din == e, "R4 bit value", cfg_din, e);
                end
                if (mode == MODE_OK && rises == exp_rises) cfg_status <= 1'b1;
            end else if (cfg_cclk) begin
                hi_run++;
            end
            if (!cfg_cclk && prev_cclk) begin
                chk(hi_run == 2*p_exp, "R5 cclk high width", hi_run, 2*p_exp);
                fall_seen = 1'b1;
                fall_gap  = 1;
            end else if (fall_seen && busy) begin
                fall_gap++;
            end
            prev_cclk <= cfg_cclk;
        end
    end

    // driver: pushes expected bits, runs one configuration
    task automatic run_cfg(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           input int n, input int phase, input int md, input int stall,
                           input bit poke, input string tag);
        logic [7:0] bytes [3];
        int exp_err;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        mode = md;
        p_exp = (phase == 0) ? 1 : phase;
        rises = 0; prog_lo = 0; clr_cnt = 0; clr_meas = -1; hi_run = 0;
        fall_gap = 0; clr_state = 0; ready_seen = 0; fall_seen = 0;
        exp_q.delete();
        exp_rises = (md == MODE_STUCK) ? 0 : 8*n;
        if (md != MODE_STUCK)
            for (int i = 0; i < n; i++)
                for (int k = 7; k >= 0; k--) exp_q.push_back(bytes[i][k]);
        exp_err = (md == MODE_STUCK) ? 1 : (md == MODE_NEVER) ? 2 : 0;

        @(negedge clk);
        byte_total = CNT_W'(n);
        phase_cycles = PH_W'(phase);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: accepted start clears done and raises busy
        chk(busy && !done, {"R11 start clears done ", tag}, {busy, done}, 2'b10);

        if (md != MODE_STUCK) begin
            for (int i = 0; i < n; i++) begin
                while (!in_ready) @(negedge clk);
                repeat (stall) begin
                    @(negedge clk);
                    // R8: CCLK low while stalled
                    chk(!cfg_cclk && in_ready, {"R8 stall ", tag}, cfg_cclk, 0);
                end
                in_data  = bytes[i];
                in_valid = 1'b1;
                @(negedge clk);
                in_valid = 1'b0;
                if (poke && i == 0) begin
                    repeat (3) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        end
        while (!done) @(negedge clk);

        chk(prog_lo == p_exp, {"R1 prog width ", tag}, prog_lo, p_exp);
        chk(int'(err_code) == exp_err, {"R6 result code ", tag}, err_code, exp_err);
        chk(ok == (exp_err == 0), {"R6 ok flag ", tag}, ok, exp_err == 0);
        chk(rises == exp_rises, {"R4 clock count ", tag}, rises, exp_rises);
        chk(exp_q.size() == 0, {"R4 bits left ", tag}, exp_q.size(), 0);
        if (md == MODE_STUCK || n == 0)
            chk(!ready_seen && rises == 0, {"R3 R12 no data phase ", tag}, ready_seen, 0);
        else begin
            chk(clr_meas == CLEAR, {"R2 clear wait ", tag}, clr_meas, CLEAR);
            chk(fall_gap == p_exp + 4, {"R9 result latency ", tag}, fall_gap, p_exp + 4);
        end
        repeat (15) @(negedge clk);
        chk(done && !busy && int'(err_code) == exp_err && !cfg_cs,
            {"R11 result held ", tag}, err_code, exp_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !done && !cfg_cclk && !cfg_cs && !in_ready && cfg_prog_n,
            "R13 reset state", {busy, done, cfg_cclk, cfg_cs, in_ready, cfg_prog_n}, 6'b000001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && cfg_prog_n && !cfg_cs, "R13 idle after reset", busy, 0);

        run_cfg(8'hA5, 8'h01, 8'h80, 3, 1, MODE_OK,    0, 1'b0, "R4 ok p1");
        run_cfg(8'hC3, 8'h5A, 8'h00, 2, 3, MODE_OK,    5, 1'b1, "R5 R8 R10 p3 stall");
        run_cfg(8'hFF, 8'h00, 8'h00, 2, 2, MODE_STUCK, 0, 1'b0, "R3 no ack");
        run_cfg(8'h96, 8'h00, 8'h00, 1, 2, MODE_NEVER, 0, 1'b0, "R6 not done");
        run_cfg(8'h81, 8'h00, 8'h00, 1, 0, MODE_OK,    1, 1'b0, "R7 phase zero");
        run_cfg(8'h00, 8'h00, 8'h00, 0, 2, MODE_NEVER, 0, 1'b0, "R12 empty");

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule